// File: doc/BRIEF.md
# Full-Address DMA Channel Engine

This block is one DMA channel that copies data between two memory locations, both given by full addresses. Software programs a source address, a destination address, a transfer count, an optional block size and a control word through a small register port. Then it arms the channel with two separate enable bits. Each accepted request from the selected request line causes one or more read-then-write pairs on a simple memory-master port. Each unit is one byte or one 16-bit word.

Each address register can independently count up, count down or stay put after every unit. The step is 1 for bytes and 2 for words. In normal operation one request moves one unit. In block operation one request moves a whole block, and the count register then counts blocks instead of units. When the count runs out, the channel disarms itself. If enabled, it raises an interrupt that stays up until software writes the enable register.

Top module: `dma_fa_chan`

## Requirements
- R1: After reset every register reads 0, `mem_req_o` is 0 and `irq_o` is 0. Register addresses: 0 source, 1 destination, 2 count, 3 block size, 4 control, 5 enable.
- R2: A request is accepted only while enable-register bit 0 (channel enable), enable-register bit 1 (master enable) and control bit 10 (full-address mode) are all 1.
- R3: Control bits 9:6 select which `req_i` line starts a transfer, and the other lines are ignored.
- R4: Each unit is a read at the source bus address (`mem_we_o`=0) followed by a write of the same data at the destination bus address (`mem_we_o`=1). A byte unit carries data in bits 7:0 with bits 15:8 zero on the write.
- R5: Control bit 0 selects word size (1) or byte size (0) and drives `mem_size_o`. Control bits 2:1 set the source update and bits 4:3 set the destination update. In each pair the upper bit enables the update and the lower bit picks down (1) or up (0). The step is 2 for words and 1 for bytes, and in word size the bus address has bit 0 forced to 0.
- R6: With control bit 5 clear, each accepted request moves exactly one unit and the count register decreases by one.
- R7: With control bit 5 set, each accepted request moves as many units as the block-size register holds. The count register then decreases by one per completed block.
- R8: When the count reaches zero, enable-register bit 0 reads 0 and further requests move nothing.
- R9: If enable-register bit 2 is 1 at completion, `irq_o` goes high and stays high until the enable register is written or bit 2 is cleared. With bit 2 at 0, `irq_o` stays low.
- R10: Writes to registers 0 to 4 are ignored while a transfer is in progress. Writes to the enable register always take effect.
- R11: A request is not accepted when the count register is 0, or when block mode is selected with a block size of 0.
- R12: While `mem_req_o` is high and `mem_ack_i` is low, the request, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | REG_DW | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | REG_DW | Register read data for `reg_addr_i` |
| req_i | input | NUM_REQ | Transfer request lines |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_size_o | output | 1 | 1 for word, 0 for byte |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Access completes in this cycle |
| irq_o | output | 1 | Transfer-end interrupt |

## Verification
The assertions assume that the memory side only acknowledges a pending request. They also assume that an acknowledged read returns its data in the same cycle. The bench memory meets this by forming its acknowledge as the request gated with a stall pattern, so every third cycle is a wait state. The bench also assumes that software keeps source and destination regions apart, and it chooses non-overlapping address ranges in every test. That way the expected data depends only on the initial memory pattern.

// File: rtl/dma_fa_pkg.sv
package dma_fa_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } chan_st_e;

    typedef enum logic [2:0] {
        RA_SRC  = 3'd0,
        RA_DST  = 3'd1,
        RA_CNT  = 3'd2,
        RA_BLK  = 3'd3,
        RA_CTRL = 3'd4,
        RA_ENA  = 3'd5
    } reg_sel_e;

    // upd = 0 holds the address; down selects decrement when upd = 1
    typedef struct packed {
        logic upd;
        logic down;
    } step_mode_t;

    typedef struct packed {
        logic             fam;
        logic [SEL_W-1:0] src_sel;
        logic             blk;
        step_mode_t       dst_mode;
        step_mode_t       src_mode;
        logic             word;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dma_fa_addr_unit.sv
module dma_fa_addr_unit
    import dma_fa_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  step_mode_t    mode_i,
    input  logic          word_i,
    output logic [AW-1:0] next_o,
    output logic [AW-1:0] bus_o
);
    logic [AW-1:0] step;

    always_comb begin
        step = word_i ? AW'(2) : AW'(1);
        if (!mode_i.upd) begin
            next_o = addr_i;
        end else if (mode_i.down) begin
            next_o = addr_i - step;
        end else begin
            next_o = addr_i + step;
        end
        bus_o = {addr_i[AW-1:1], addr_i[0] & ~word_i};
    end

endmodule

// File: rtl/dma_fa_req_sel.sv
module dma_fa_req_sel
    import dma_fa_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);
    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (sel_i == SEL_W'(i)) begin
                hit_o = hit_o | req_i[i];
            end
        end
    end

endmodule

// File: rtl/dma_fa_chan.sv
module dma_fa_chan
    import dma_fa_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int BLK_W   = 8,
    parameter int NUM_REQ = 16,
    parameter int REG_DW  = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [2:0]         reg_addr_i,
    input  logic [REG_DW-1:0]  reg_wdata_i,
    input  logic               reg_we_i,
    output logic [REG_DW-1:0]  reg_rdata_o,
    input  logic [NUM_REQ-1:0] req_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic               mem_size_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    input  logic               mem_ack_i,
    output logic               irq_o
);
    localparam int NSIDE = 2;

    typedef struct packed {
        chan_st_e          st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [BLK_W-1:0]  blk_size;
        logic [BLK_W-1:0]  blk_rem;
        ctrl_t             ctrl;
        logic              chan_en;
        logic              master_en;
        logic              irq_en;
        logic              end_flag;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t q, d;

    logic              req_hit;
    logic              armed;
    logic              startable;
    logic              cfg_wr;
    logic              unused_bits;
    logic [ADDR_W-1:0] side_addr [NSIDE];
    step_mode_t        side_mode [NSIDE];
    logic [ADDR_W-1:0] side_next [NSIDE];
    logic [ADDR_W-1:0] side_bus  [NSIDE];

    // signals exposed to the bound checker
    logic chan_en_w, master_en_w, irq_en_w, busy_w;

    assign unused_bits = ^reg_wdata_i;

    dma_fa_req_sel #(.NUM_REQ(NUM_REQ)) u_req_sel (
        .req_i (req_i),
        .sel_i (q.ctrl.src_sel),
        .hit_o (req_hit)
    );

    assign side_addr[0] = q.src;
    assign side_addr[1] = q.dst;
    assign side_mode[0] = q.ctrl.src_mode;
    assign side_mode[1] = q.ctrl.dst_mode;

    generate
        for (genvar g = 0; g < NSIDE; g++) begin : g_side
            dma_fa_addr_unit #(.AW(ADDR_W)) u_addr (
                .addr_i (side_addr[g]),
                .mode_i (side_mode[g]),
                .word_i (q.ctrl.word),
                .next_o (side_next[g]),
                .bus_o  (side_bus[g])
            );
        end
    endgenerate

    always_comb begin
        d         = q;
        cfg_wr    = reg_we_i && (q.st == ST_IDLE);
        armed     = q.chan_en && q.master_en && q.ctrl.fam;
        startable = armed && (q.cnt != '0) && (!q.ctrl.blk || (q.blk_size != '0));

        // register port
        if (cfg_wr) begin
            case (reg_sel_e'(reg_addr_i))
                RA_SRC:  d.src      = reg_wdata_i[ADDR_W-1:0];
                RA_DST:  d.dst      = reg_wdata_i[ADDR_W-1:0];
                RA_CNT:  d.cnt      = reg_wdata_i[CNT_W-1:0];
                RA_BLK:  d.blk_size = reg_wdata_i[BLK_W-1:0];
                RA_CTRL: d.ctrl     = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
                default: ;
            endcase
        end
        if (reg_we_i && (reg_sel_e'(reg_addr_i) == RA_ENA)) begin
            d.chan_en   = reg_wdata_i[0];
            d.master_en = reg_wdata_i[1];
            d.irq_en    = reg_wdata_i[2];
            d.end_flag  = 1'b0;
        end

        // transfer sequencer
        case (q.st)
            ST_IDLE: begin
                if (startable && req_hit) begin
                    d.st      = ST_READ;
                    d.blk_rem = q.ctrl.blk ? q.blk_size : BLK_W'(1);
                end
            end
            ST_READ: begin
                if (mem_ack_i) begin
                    d.data = mem_rdata_i;
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack_i) begin
                    d.src     = side_next[0];
                    d.dst     = side_next[1];
                    d.blk_rem = q.blk_rem - BLK_W'(1);
                    if (q.blk_rem == BLK_W'(1)) begin
                        d.cnt = q.cnt - CNT_W'(1);
                        d.st  = ST_IDLE;
                        if (q.cnt == CNT_W'(1)) begin
                            d.chan_en  = 1'b0;
                            d.end_flag = 1'b1;
                        end
                    end else if (!(q.chan_en && q.master_en)) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_addr_i))
            RA_SRC:  reg_rdata_o = REG_DW'(q.src);
            RA_DST:  reg_rdata_o = REG_DW'(q.dst);
            RA_CNT:  reg_rdata_o = REG_DW'(q.cnt);
            RA_BLK:  reg_rdata_o = REG_DW'(q.blk_size);
            RA_CTRL: reg_rdata_o = REG_DW'(q.ctrl);
            RA_ENA:  reg_rdata_o = REG_DW'({q.irq_en, q.master_en, q.chan_en});
            default: reg_rdata_o = '0;
        endcase
    end

    assign mem_req_o   = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we_o    = (q.st == ST_WRITE);
    assign mem_size_o  = q.ctrl.word;
    assign mem_addr_o  = (q.st == ST_WRITE) ? side_bus[1] : side_bus[0];
    assign mem_wdata_o = q.ctrl.word ? q.data
                                     : {{(DATA_W-BYTE_W){1'b0}}, q.data[BYTE_W-1:0]};
    assign irq_o       = q.end_flag && q.irq_en;

    assign chan_en_w   = q.chan_en;
    assign master_en_w = q.master_en;
    assign irq_en_w    = q.irq_en;
    assign busy_w      = (q.st != ST_IDLE);

endmodule

// File: rtl/dma_fa_chan_chk.sv
module dma_fa_chan_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          mem_req_i,
    input logic          mem_we_i,
    input logic          mem_size_i,
    input logic [AW-1:0] mem_addr_i,
    input logic [DW-1:0] mem_wdata_i,
    input logic          mem_ack_i,
    input logic          irq_i,
    input logic          chan_en_i,
    input logic          master_en_i,
    input logic          irq_en_i,
    input logic          busy_i
);

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i)
                                   && $stable(mem_we_i) && $stable(mem_wdata_i)); // R12

    AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_i && mem_size_i |-> !mem_addr_i[0]); // R5

    AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_i && !mem_we_i && mem_ack_i |=> mem_req_i && mem_we_i); // R4

    AST_START_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_i) |-> $past(chan_en_i && master_en_i)); // R2

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> irq_en_i); // R9

    AST_IRQ_AFTER_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> !chan_en_i); // R8

endmodule

bind dma_fa_chan dma_fa_chan_chk #(.AW(ADDR_W), .DW(dma_fa_pkg::DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_req_i   (mem_req_o),
    .mem_we_i    (mem_we_o),
    .mem_size_i  (mem_size_o),
    .mem_addr_i  (mem_addr_o),
    .mem_wdata_i (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .irq_i       (irq_o),
    .chan_en_i   (chan_en_w),
    .master_en_i (master_en_w),
    .irq_en_i    (irq_en_w),
    .busy_i      (busy_w)
);

// File: tb/dma_fa_chan_bench.sv
module dma_fa_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [15:0] req = '0;
    logic        mem_req, mem_we, mem_size, mem_ack, irq;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        ack_en = 1'b0;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic [7:0]  mem [256];

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] d;
        logic        w;
    } item_t;
    item_t sbq[$];

    logic [15:0] m_src, m_dst;
    logic [1:0]  m_smode, m_dmode;
    logic        m_word;

    localparam logic [1:0] FIX = 2'b00, INC = 2'b10, DEC = 2'b11;

    always #5 clk = ~clk;

    dma_fa_chan u_dma_fa_chan (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_we_i    (reg_we),
        .reg_rdata_o (reg_rdata),
        .req_i       (req),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_size_o  (mem_size),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_ack_i   (mem_ack),
        .irq_o       (irq)
    );

    // memory model: one wait state out of every three cycles
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        ack_en <= (cyc % 3) != 1;
    end
    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = mem_size ? {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]}
                                : {8'h00, mem[mem_addr[7:0]]};

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 5);
    endfunction

    function automatic logic [15:0] step(input logic [15:0] a, input logic [1:0] m,
                                         input logic w);
        logic [15:0] s;
        s = w ? 16'd2 : 16'd1;
        if (!m[1]) return a;
        return m[0] ? a - s : a + s;
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic fam, input logic [3:0] sel,
                                            input logic blk, input logic [1:0] dm,
                                            input logic [1:0] sm, input logic w);
        return {21'd0, fam, sel, blk, dm, sm, w};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        req[line] = 1'b1;
        @(negedge clk);
        req = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_model(input logic [15:0] s, input logic [1:0] sm,
                             input logic [15:0] dd, input logic [1:0] dm, input logic w);
        m_src = s; m_dst = dd; m_smode = sm; m_dmode = dm; m_word = w;
    endtask

    // driver side of the scoreboard: expected writes for n units
    task automatic push_units(input int n);
        item_t it;
        logic [15:0] sa;
        for (int k = 0; k < n; k++) begin
            sa   = m_word ? {m_src[15:1], 1'b0} : m_src;
            it.a = m_word ? {m_dst[15:1], 1'b0} : m_dst;
            it.d = m_word ? {pat(int'(sa[7:0]) + 1), pat(int'(sa[7:0]))}
                          : {8'h00, pat(int'(sa[7:0]))};
            it.w = m_word;
            sbq.push_back(it);
            m_src = step(m_src, m_smode, m_word);
            m_dst = step(m_dst, m_dmode, m_word);
        end
    endtask

    // monitor side of the scoreboard and memory write port
    initial begin : monitor
        item_t e;
        logic        stall_prev;
        logic [15:0] prev_addr;
        stall_prev = 1'b0;
        prev_addr  = '0;
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (stall_prev) chk("R12 address held during wait", 32'(mem_addr), 32'(prev_addr));
                if (mem_req && mem_ack && mem_we) begin
                    if (sbq.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R2 unexpected write: actual addr %h data %h expected no write",
                                 mem_addr, mem_wdata);
                    end else begin
                        e = sbq.pop_front();
                        chk("R5 write address", 32'(mem_addr), 32'(e.a));
                        chk("R4 write data", 32'(mem_wdata), 32'(e.d));
                        chk("R5 write size", 32'(mem_size), 32'(e.w));
                    end
                    if (mem_size) begin
                        mem[{mem_addr[7:1], 1'b0}] = mem_wdata[7:0];
                        mem[{mem_addr[7:1], 1'b1}] = mem_wdata[15:8];
                    end else begin
                        mem[mem_addr[7:0]] = mem_wdata[7:0];
                    end
                end
                stall_prev = mem_req && !mem_ack;
                prev_addr  = mem_addr;
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;

        // reset state (R1)
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 no request", 32'(mem_req), 32'h0);
        chk("R1 irq low", 32'(irq), 32'h0);

        // normal byte mode, both up, request line 5 (R3 R4 R6 R8 R9)
        wr(3'd0, 32'h10); wr(3'd1, 32'h80); wr(3'd2, 32'd3);
        wr(3'd4, mk_ctrl(1'b1, 4'd5, 1'b0, INC, INC, 1'b0));
        wr(3'd5, 32'h7);
        set_model(16'h10, INC, 16'h80, INC, 1'b0);
        for (int k = 0; k < 3; k++) begin
            push_units(1);
            pulse(5);
            idle(20);
            chk("R6 one unit per request", 32'(sbq.size()), 32'h0);
            rd(3'd2, v);
            chk("R6 count per unit", v, 32'(2 - k));
        end
        rd(3'd0, v); chk("R5 source stepped up", v, 32'h13);
        rd(3'd1, v); chk("R5 destination stepped up", v, 32'h83);
        rd(3'd5, v); chk("R8 channel enable cleared", v, 32'h6);
        chk("R9 irq raised at end", 32'(irq), 32'h1);
        pulse(5); idle(20);
        rd(3'd2, v); chk("R8 no transfer after end", v, 32'h0);
        chk("R9 irq held", 32'(irq), 32'h1);
        wr(3'd5, 32'h6);
        chk("R9 irq cleared by enable write", 32'(irq), 32'h0);

        // word mode, source down from odd address, destination held, irq off (R5 R9)
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h41); wr(3'd1, 32'h91); wr(3'd2, 32'd2);
        wr(3'd4, mk_ctrl(1'b1, 4'd2, 1'b0, FIX, DEC, 1'b1));
        wr(3'd5, 32'h3);
        set_model(16'h41, DEC, 16'h91, FIX, 1'b1);
        push_units(2);
        pulse(2); idle(20);
        pulse(2); idle(20);
        chk("R5 word units done", 32'(sbq.size()), 32'h0);
        rd(3'd0, v); chk("R5 source stepped down by 2", v, 32'h3D);
        rd(3'd1, v); chk("R5 destination held", v, 32'h91);
        rd(3'd5, v); chk("R8 enable cleared word run", v, 32'h2);
        chk("R9 no irq when disabled", 32'(irq), 32'h0);

        // block mode: 3 units per request, 2 blocks (R7)
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h20); wr(3'd1, 32'hC0); wr(3'd2, 32'd2); wr(3'd3, 32'd3);
        wr(3'd4, mk_ctrl(1'b1, 4'd9, 1'b1, DEC, INC, 1'b0));
        wr(3'd5, 32'h3);
        set_model(16'h20, INC, 16'hC0, DEC, 1'b0);
        push_units(3);
        pulse(9); idle(40);
        chk("R7 full block per request", 32'(sbq.size()), 32'h0);
        rd(3'd2, v); chk("R7 count per block", v, 32'h1);
        rd(3'd5, v); chk("R7 still armed mid run", v, 32'h3);
        push_units(3);
        pulse(9); idle(40);
        chk("R7 second block", 32'(sbq.size()), 32'h0);
        rd(3'd2, v); chk("R7 count exhausted", v, 32'h0);
        rd(3'd0, v); chk("R7 source after blocks", v, 32'h26);
        rd(3'd1, v); chk("R7 destination after blocks", v, 32'hBA);
        rd(3'd5, v); chk("R8 enable cleared block run", v, 32'h2);

        // arming, request select, zero counts (R2 R3 R11)
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h30); wr(3'd1, 32'hA0); wr(3'd2, 32'd1); wr(3'd3, 32'd0);
        wr(3'd4, mk_ctrl(1'b1, 4'd7, 1'b0, INC, INC, 1'b0));
        wr(3'd5, 32'h1);
        pulse(7); idle(15);
        rd(3'd2, v); chk("R2 channel enable alone", v, 32'h1);
        wr(3'd5, 32'h2);
        pulse(7); idle(15);
        rd(3'd2, v); chk("R2 master enable alone", v, 32'h1);
        wr(3'd4, mk_ctrl(1'b0, 4'd7, 1'b0, INC, INC, 1'b0));
        wr(3'd5, 32'h3);
        pulse(7); idle(15);
        rd(3'd2, v); chk("R2 full-address bit clear", v, 32'h1);
        wr(3'd4, mk_ctrl(1'b1, 4'd7, 1'b0, INC, INC, 1'b0));
        pulse(6); idle(15);
        rd(3'd2, v); chk("R3 other line ignored", v, 32'h1);
        wr(3'd4, mk_ctrl(1'b1, 4'd7, 1'b1, INC, INC, 1'b0));
        pulse(7); idle(15);
        rd(3'd2, v); chk("R11 block size zero", v, 32'h1);
        wr(3'd4, mk_ctrl(1'b1, 4'd7, 1'b0, INC, INC, 1'b0));
        wr(3'd2, 32'd0);
        pulse(7); idle(15);
        rd(3'd5, v); chk("R11 count zero keeps armed", v, 32'h3);
        rd(3'd0, v); chk("R11 count zero no step", v, 32'h30);
        wr(3'd2, 32'd1);
        set_model(16'h30, INC, 16'hA0, INC, 1'b0);
        push_units(1);
        pulse(7); idle(15);
        chk("R2 armed transfer", 32'(sbq.size()), 32'h0);
        rd(3'd5, v); chk("R8 enable cleared", v, 32'h2);

        // configuration locked while busy (R10)
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h50); wr(3'd1, 32'hD0); wr(3'd2, 32'd1); wr(3'd3, 32'd4);
        wr(3'd4, mk_ctrl(1'b1, 4'd1, 1'b1, INC, INC, 1'b0));
        wr(3'd5, 32'h3);
        set_model(16'h50, INC, 16'hD0, INC, 1'b0);
        push_units(4);
        pulse(1);
        wr(3'd0, 32'h70);
        wr(3'd2, 32'd5);
        idle(40);
        chk("R10 block done", 32'(sbq.size()), 32'h0);
        rd(3'd0, v); chk("R10 source write ignored", v, 32'h54);
        rd(3'd2, v); chk("R10 count write ignored", v, 32'h0);

        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule